// File: doc/BRIEF.md
# Two-Wire Bus Master Command Sequencer

This block is the command engine for one channel of a two-wire serial bus master. Host software loads a byte buffer and then writes a command word. That word may ask for a start with address, a data byte send, a byte receive (the last one of a read NACKed), and a stop. The engine works through whichever requests are present, always in the order start, send, receive, stop. Each step becomes one byte-level request on a link port, and a lower-level bit engine carries it out. The engine records the result in write-one-to-clear status flags and raises an interrupt through an enable mask.

A 4-bit bus state code appears in the command register on read-back. A host driver can use it to tell a repeated start from a first start and to spot a stop issued outside a transfer. While a command is being worked, register writes are stalled by a ready signal, so the buffer and command bits cannot change under a live request. A receive is deferred while the previous byte's receive-done flag is still set. Clearing that flag with a pending receive request resumes reception on its own.

Top module: `tw_master_seq`

## Requirements
- R1: Registers sit at byte offsets control 0x00, timing-A 0x04, timing-B 0x08, interrupt enable 0x0C, status 0x10, command 0x14 and buffer 0x20. Control keeps only the bits of 0x0071C3FF, timing-A keeps 0x0FFFFF0F, timing-B keeps 0x7 and enable keeps 0x7FFF. A buffer write loads bits [7:0] and zeroes bits [15:8]. Any other offset reads as all ones. Read data is registered and appears one cycle after the address.
- R2: A command write replaces command bits [15:0], but only when control bit 0 (master enable) is set; otherwise it has no effect. Command bits: 0 start, 1 send, 2 reserved, 3 receive, 4 receive-last, 5 stop. Read-back puts the state code in bits [22:19] and the link's bus-busy input in bit 16.
- R3: A start issues link op 0 carrying buffer bits [7:0] (address in [7:1], direction in [0]). During the start the state code is 0xA if the prior code had bit 3 set, and 0x9 otherwise. The start clears command bits 0 and 1. An ACK sets status bit 0 and a NACK sets status bit 1.
- R4: If the bus reports not busy when the start completes, the rest of the command is abandoned. The state code stays at the start code and the unexecuted command bits remain set.
- R5: A send issues link op 1 with buffer bits [7:0] and shows state 0xC. An ACK sets status bit 0. A NACK sets status bit 1 and is followed by a link op 3 that does not set the normal-stop flag. Either way the state then returns to 0x8.
- R6: A receive issues link op 2 with the NACK flag equal to command bit 4 and shows state 0xE. The received byte goes to buffer bits [15:8], with bits [7:0] zeroed. The receive sets status bit 2, clears command bits 3 and 4, and returns the state to 0x8.
- R7: A receive is skipped while status bit 2 is set, and its command bits stay pending. Writing 1 to status bit 2 while it is set, with command bit 3 or 4 pending, starts that receive at once.
- R8: With state bit 3 set, a stop issues link op 3, shows state 0xB and sets status bit 4. Otherwise it issues nothing and sets status bit 5. In both cases command bit 5 clears and the state ends at 0x0.
- R9: One command write runs start, send, receive and stop in that fixed order, and the state is 0x8 between phases.
- R10: Writing 1 to any of status bits [14:0] clears that bit. The interrupt output is the OR of status AND enable, registered one cycle later.
- R11: While a command is executing, the write-ready output is low and register writes are stalled. A link request holds its op, byte and NACK flag stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write request, held until accepted |
| host_addr | input | ADDR_W | Register byte offset for read and write |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | Engine idle; a write is accepted on this cycle |
| host_rdata | output | DATA_W | Registered read data for host_addr |
| irq | output | 1 | Interrupt, OR of enabled status bits |
| lnk_valid | output | 1 | Byte-level request pending |
| lnk_op | output | 2 | 0 start+address, 1 send, 2 receive, 3 stop |
| lnk_byte | output | 8 | Address or data byte to send |
| lnk_nack | output | 1 | For a receive: NACK the byte |
| lnk_ready | input | 1 | Request accepted and completed this cycle |
| lnk_ack | input | 1 | Start/send result, 1 = acknowledged |
| lnk_rbyte | input | 8 | Received byte, valid with lnk_ready |
| lnk_busy | input | 1 | Bus currently owned by a transfer |

## Verification
Read data is due one cycle after the address is presented, and irq follows a status or enable change by one further cycle. The bench therefore samples on the falling edge after the address edge and waits a few cycles before looking at irq. A command takes a variable number of cycles: one evaluation cycle per phase, plus the link handshake. The bench does not count cycles for it. It waits for host_ready to rise and then checks the logged link requests, the status and the command read-back. To observe the transient state codes 0x9, 0xA, 0xB, 0xC and 0xE, the bench holds lnk_ready low, waits until lnk_valid is seen, and reads the command register while the request is stalled.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 16;
  localparam int STS_W  = 15;

  // register byte offsets
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_TIMA = 8'h04;
  localparam logic [7:0] OFS_TIMB = 8'h08;
  localparam logic [7:0] OFS_IEN  = 8'h0C;
  localparam logic [7:0] OFS_STS  = 8'h10;
  localparam logic [7:0] OFS_CMD  = 8'h14;
  localparam logic [7:0] OFS_BUF  = 8'h20;

  // command bit positions
  localparam int CB_START = 0;
  localparam int CB_SEND  = 1;
  localparam int CB_RECV  = 3;
  localparam int CB_LAST  = 4;
  localparam int CB_STOP  = 5;

  // status bit positions
  localparam int SB_ACK   = 0;
  localparam int SB_NAK   = 1;
  localparam int SB_RXD   = 2;
  localparam int SB_STOP  = 4;
  localparam int SB_ABN   = 5;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } link_op_e;

  localparam logic [3:0] ST_IDLE    = 4'h0;
  localparam logic [3:0] ST_ACTIVE  = 4'h8;
  localparam logic [3:0] ST_START   = 4'h9;
  localparam logic [3:0] ST_RESTART = 4'hA;
  localparam logic [3:0] ST_STOPPING= 4'hB;
  localparam logic [3:0] ST_TXD     = 4'hC;
  localparam logic [3:0] ST_RXD     = 4'hE;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_SEND  = 3'd2,
    PH_TXEND = 3'd3,
    PH_RECV  = 3'd4,
    PH_STOP  = 3'd5
  } phase_e;
endpackage

// File: rtl/tw_regfile.sv
module tw_regfile
  import tw_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] CTRL_MASK = 32'h0071_C3FF,
  parameter logic [31:0] TIMA_MASK = 32'h0FFF_FF0F,
  parameter logic [31:0] TIMB_MASK = 32'h0000_0007
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cmd_view,
  input  logic [STS_W-1:0]  sts_set,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [DATA_W-1:0] rdata,
  output logic              master_en,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              rx_done,
  output logic              rx_resume,
  output logic              ien_any,
  output logic              irq
);
  localparam int BUF_W = 2 * BYTE_W;

  logic [DATA_W-1:0] ctrl_q, tima_q, timb_q;
  logic [STS_W-1:0]  ien_q, sts_q;
  logic [BUF_W-1:0]  buf_q;

  logic sel_ctrl, sel_tima, sel_timb, sel_ien, sel_sts, sel_buf;
  always_comb begin
    sel_ctrl = (addr == OFS_CTRL[ADDR_W-1:0]);
    sel_tima = (addr == OFS_TIMA[ADDR_W-1:0]);
    sel_timb = (addr == OFS_TIMB[ADDR_W-1:0]);
    sel_ien  = (addr == OFS_IEN[ADDR_W-1:0]);
    sel_sts  = (addr == OFS_STS[ADDR_W-1:0]);
    sel_buf  = (addr == OFS_BUF[ADDR_W-1:0]);
  end

  assign rx_done   = sts_q[SB_RXD];
  assign rx_resume = wr_fire && sel_sts && sts_q[SB_RXD] && wdata[SB_RXD];
  assign master_en = ctrl_q[0];
  assign tx_byte   = buf_q[BYTE_W-1:0];
  assign ien_any   = |ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      tima_q <= '0;
      timb_q <= '0;
      ien_q  <= '0;
      sts_q  <= '0;
      buf_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_fire && sel_ctrl) ctrl_q <= wdata & CTRL_MASK[DATA_W-1:0];
      if (wr_fire && sel_tima) tima_q <= wdata & TIMA_MASK[DATA_W-1:0];
      if (wr_fire && sel_timb) timb_q <= wdata & TIMB_MASK[DATA_W-1:0];
      if (wr_fire && sel_ien)  ien_q  <= wdata[STS_W-1:0];
      if (wr_fire && sel_sts)
        sts_q <= (sts_q & ~wdata[STS_W-1:0]) | sts_set;
      else
        sts_q <= sts_q | sts_set;
      if (rx_load)
        buf_q <= {rx_byte, {BYTE_W{1'b0}}};
      else if (wr_fire && sel_buf)
        buf_q <= {{BYTE_W{1'b0}}, wdata[BYTE_W-1:0]};
      irq <= |(sts_q & ien_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '1;
      if (sel_ctrl) rdata <= ctrl_q;
      if (sel_tima) rdata <= tima_q;
      if (sel_timb) rdata <= timb_q;
      if (sel_ien)  rdata <= DATA_W'(ien_q);
      if (sel_sts)  rdata <= DATA_W'(sts_q);
      if (sel_buf)  rdata <= DATA_W'(buf_q);
      if (addr == OFS_CMD[ADDR_W-1:0]) rdata <= cmd_view;
    end
  end
endmodule

// File: rtl/tw_sequencer.sv
module tw_sequencer
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              master_en,
  input  logic              rx_resume,
  input  logic              rx_done,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              lnk_valid,
  output logic [1:0]        lnk_op,
  output logic [BYTE_W-1:0] lnk_byte,
  output logic              lnk_nack,
  input  logic              lnk_ready,
  input  logic              lnk_ack,
  input  logic [BYTE_W-1:0] lnk_rbyte,
  input  logic              lnk_busy,
  output logic [CMD_W-1:0]  cmd_bits,
  output logic [3:0]        state_code,
  output logic              idle,
  output logic [STS_W-1:0]  sts_set,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte
);
  phase_e           ph_q;
  logic             act_q, only_q;
  logic [CMD_W-1:0] cmd_q;
  logic [3:0]       st_q;
  logic             go, rx_pend;

  assign cmd_bits   = cmd_q;
  assign state_code = st_q;
  assign idle       = (ph_q == PH_IDLE);
  assign go         = lnk_valid && lnk_ready;
  assign rx_pend    = cmd_q[CB_RECV] || cmd_q[CB_LAST];

  // link request, derived from registers only
  always_comb begin
    lnk_valid = act_q && (ph_q != PH_IDLE);
    lnk_byte  = tx_byte;
    lnk_nack  = 1'b0;
    case (ph_q)
      PH_START: lnk_op = OP_START;
      PH_SEND:  lnk_op = OP_SEND;
      PH_RECV:  begin lnk_op = OP_RECV; lnk_nack = cmd_q[CB_LAST]; end
      default:  lnk_op = OP_STOP;
    endcase
  end

  // status set pulses
  always_comb begin
    sts_set = '0;
    if (go && (ph_q == PH_START || ph_q == PH_SEND)) begin
      sts_set[SB_ACK] = lnk_ack;
      sts_set[SB_NAK] = !lnk_ack;
    end
    if (go && ph_q == PH_RECV) sts_set[SB_RXD] = 1'b1;
    if (go && ph_q == PH_STOP) sts_set[SB_STOP] = 1'b1;
    if (!act_q && ph_q == PH_STOP && cmd_q[CB_STOP] && !st_q[3])
      sts_set[SB_ABN] = 1'b1;
  end

  assign rx_load = go && (ph_q == PH_RECV);
  assign rx_byte = lnk_rbyte;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      act_q  <= 1'b0;
      only_q <= 1'b0;
      cmd_q  <= '0;
      st_q   <= ST_IDLE;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (cmd_wr && master_en) begin
            cmd_q  <= cmd_wdata;
            ph_q   <= PH_START;
            act_q  <= 1'b0;
            only_q <= 1'b0;
          end else if (rx_resume && rx_pend) begin
            ph_q   <= PH_RECV;
            act_q  <= 1'b0;
            only_q <= 1'b1;
          end
        end
        PH_START: begin
          if (!act_q) begin
            if (cmd_q[CB_START]) begin
              st_q  <= st_q[3] ? ST_RESTART : ST_START;
              act_q <= 1'b1;
            end else begin
              ph_q <= PH_SEND;
            end
          end else if (go) begin
            cmd_q[CB_START] <= 1'b0;
            cmd_q[CB_SEND]  <= 1'b0;
            act_q <= 1'b0;
            if (lnk_busy) begin
              st_q <= ST_ACTIVE;
              ph_q <= PH_SEND;
            end else begin
              ph_q <= PH_IDLE;
            end
          end
        end
        PH_SEND: begin
          if (!act_q) begin
            if (cmd_q[CB_SEND]) begin
              st_q  <= ST_TXD;
              act_q <= 1'b1;
            end else begin
              ph_q <= PH_RECV;
            end
          end else if (go) begin
            cmd_q[CB_SEND] <= 1'b0;
            st_q <= ST_ACTIVE;
            if (lnk_ack) begin
              ph_q  <= PH_RECV;
              act_q <= 1'b0;
            end else begin
              ph_q <= PH_TXEND;
            end
          end
        end
        PH_TXEND: begin
          if (go) begin
            ph_q  <= PH_RECV;
            act_q <= 1'b0;
          end
        end
        PH_RECV: begin
          if (!act_q) begin
            if (rx_pend && !rx_done) begin
              st_q  <= ST_RXD;
              act_q <= 1'b1;
            end else begin
              ph_q <= only_q ? PH_IDLE : PH_STOP;
            end
          end else if (go) begin
            cmd_q[CB_RECV] <= 1'b0;
            cmd_q[CB_LAST] <= 1'b0;
            st_q  <= ST_ACTIVE;
            act_q <= 1'b0;
            ph_q  <= only_q ? PH_IDLE : PH_STOP;
          end
        end
        PH_STOP: begin
          if (!act_q) begin
            if (!cmd_q[CB_STOP]) begin
              ph_q <= PH_IDLE;
            end else if (st_q[3]) begin
              st_q  <= ST_STOPPING;
              act_q <= 1'b1;
            end else begin
              st_q <= ST_IDLE;
              cmd_q[CB_STOP] <= 1'b0;
              ph_q <= PH_IDLE;
            end
          end else if (go) begin
            st_q  <= ST_IDLE;
            cmd_q[CB_STOP] <= 1'b0;
            act_q <= 1'b0;
            ph_q  <= PH_IDLE;
          end
        end
        default: begin
          ph_q  <= PH_IDLE;
          act_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/tw_master_seq.sv
module tw_master_seq
  import tw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  output logic              lnk_valid,
  output logic [1:0]        lnk_op,
  output logic [7:0]        lnk_byte,
  output logic              lnk_nack,
  input  logic              lnk_ready,
  input  logic              lnk_ack,
  input  logic [7:0]        lnk_rbyte,
  input  logic              lnk_busy
);
  localparam int PAD_W = DATA_W - 23;

  logic              wr_fire, cmd_wr;
  logic              master_en, rx_done_w, rx_resume, ien_any, seq_idle, rx_load;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic [CMD_W-1:0]  cmd_bits;
  logic [3:0]        state_code;
  logic [STS_W-1:0]  sts_set;
  logic [DATA_W-1:0] cmd_view;

  assign host_ready = seq_idle;
  assign wr_fire    = host_we && seq_idle;
  assign cmd_wr     = wr_fire && (host_addr == OFS_CMD[ADDR_W-1:0]);
  assign cmd_view   = {{PAD_W{1'b0}}, state_code, 2'b00, lnk_busy, cmd_bits};

  tw_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .addr(host_addr),
    .wdata(host_wdata), .cmd_view(cmd_view), .sts_set(sts_set),
    .rx_load(rx_load), .rx_byte(rx_byte), .rdata(host_rdata),
    .master_en(master_en), .tx_byte(tx_byte), .rx_done(rx_done_w),
    .rx_resume(rx_resume), .ien_any(ien_any), .irq(irq)
  );

  tw_sequencer u_seq (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr),
    .cmd_wdata(host_wdata[CMD_W-1:0]), .master_en(master_en),
    .rx_resume(rx_resume), .rx_done(rx_done_w), .tx_byte(tx_byte),
    .lnk_valid(lnk_valid), .lnk_op(lnk_op), .lnk_byte(lnk_byte),
    .lnk_nack(lnk_nack), .lnk_ready(lnk_ready), .lnk_ack(lnk_ack),
    .lnk_rbyte(lnk_rbyte), .lnk_busy(lnk_busy), .cmd_bits(cmd_bits),
    .state_code(state_code), .idle(seq_idle), .sts_set(sts_set),
    .rx_load(rx_load), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/tw_master_seq_chk.sv
module tw_master_seq_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_ready,
  input logic              lnk_valid,
  input logic              lnk_ready,
  input logic [1:0]        lnk_op,
  input logic [7:0]        lnk_byte,
  input logic              lnk_nack,
  input logic              rx_done,
  input logic [3:0]        state_code,
  input logic [15:0]       cmd_bits,
  input logic              master_en,
  input logic              ien_any,
  input logic              irq
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    lnk_valid && !lnk_ready |=> lnk_valid && $stable(lnk_op) && $stable(lnk_byte) && $stable(lnk_nack));

  a_r11_writes_stalled: assert property (@(posedge clk) disable iff (rst)
    lnk_valid |-> !host_ready);

  a_r7_no_recv_while_done: assert property (@(posedge clk) disable iff (rst)
    lnk_valid && lnk_op == 2'd2 |-> !rx_done);

  a_r8_stop_ends_idle: assert property (@(posedge clk) disable iff (rst)
    lnk_valid && lnk_ready && lnk_op == 2'd3 && state_code == 4'hB |=> state_code == 4'h0);

  a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
    !ien_any |=> !irq);

  a_r2_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
    host_we && host_ready && host_addr == 6'h14 && !master_en |=> $stable(cmd_bits));
endmodule

bind tw_master_seq tw_master_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .host_ready(host_ready), .lnk_valid(lnk_valid), .lnk_ready(lnk_ready),
  .lnk_op(lnk_op), .lnk_byte(lnk_byte), .lnk_nack(lnk_nack),
  .rx_done(rx_done_w), .state_code(state_code), .cmd_bits(cmd_bits),
  .master_en(master_en), .ien_any(ien_any), .irq(irq)
);

// File: tb/tb_tw_master_seq.sv
module tb_tw_master_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready, irq, lnk_valid, lnk_nack;
  logic [31:0] host_rdata;
  logic [1:0]  lnk_op;
  logic [7:0]  lnk_byte;
  logic        hold = 1'b0, ack_start = 1'b1, ack_tx = 1'b1, busy = 1'b1;
  logic [7:0]  rbyte = 8'h00;
  logic        lnk_ready, lnk_ack;

  assign lnk_ready = !hold;
  assign lnk_ack   = (lnk_op == 2'd0) ? ack_start : ack_tx;

  always #10 clk = ~clk;

  tw_master_seq dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
    .irq(irq), .lnk_valid(lnk_valid), .lnk_op(lnk_op), .lnk_byte(lnk_byte),
    .lnk_nack(lnk_nack), .lnk_ready(lnk_ready), .lnk_ack(lnk_ack),
    .lnk_rbyte(rbyte), .lnk_busy(busy)
  );

  int total = 0, bad = 0, cyc = 0, nops = 0;
  logic [1:0] op_log [0:7];
  logic [7:0] dat_log [0:7];
  logic       nk_log [0:7];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && lnk_valid && lnk_ready && nops < 8) begin
      op_log[nops]  <= lnk_op;
      dat_log[nops] <= lnk_byte;
      nk_log[nops]  <= lnk_nack;
      nops <= nops + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!host_ready) @(negedge clk);
  endtask

  task automatic wait_req();
    while (!lnk_valid) @(negedge clk);
  endtask

  function automatic logic [31:0] cv(input logic [3:0] st, input logic b, input logic [15:0] lo);
    return (32'(st) << 19) | (32'(b) << 16) | 32'(lo);
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    rd(6'h00, v); chk("R1 reset ctrl", v, 0);
    rd(6'h10, v); chk("R10 reset status", v, 0);
    rd(6'h14, v); chk("R2 reset cmd", v, cv(4'h0, 1'b1, 16'h0));
    chk("R11 reset ready", 32'(host_ready), 1);
    chk("R10 reset irq", 32'(irq), 0);
    // register masks
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, v); chk("R1 ctrl mask", v, 32'h0071_C3FF);
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); chk("R1 timing-A mask", v, 32'h0FFF_FF0F);
    wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, v); chk("R1 timing-B mask", v, 32'h7);
    wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, v); chk("R1 enable mask", v, 32'h7FFF);
    wr(6'h0C, 32'h0);
    wr(6'h20, 32'h0000_12A4); rd(6'h20, v); chk("R1 buffer write", v, 32'hA4);
    rd(6'h3C, v); chk("R1 unmapped read", v, 32'hFFFF_FFFF);
    // command ignored without master enable
    wr(6'h00, 32'h0); nops = 0;
    wr(6'h14, 32'h3); repeat (4) @(negedge clk);
    rd(6'h14, v); chk("R2 cmd ignored", v, cv(4'h0, 1'b1, 16'h0));
    chk("R2 no link op", 32'(nops), 0);
    // first start with send bit: send is absorbed
    wr(6'h00, 32'h1); nops = 0; hold = 1'b1;
    wr(6'h14, 32'h3); wait_req();
    chk("R11 ready low while busy", 32'(host_ready), 0);
    rd(6'h14, v); chk("R3 start code", v, cv(4'h9, 1'b1, 16'h3));
    hold = 1'b0; wait_idle();
    chk("R3 one op", 32'(nops), 1);
    chk("R3 op start", 32'(op_log[0]), 0);
    chk("R3 address byte", 32'(dat_log[0]), 32'hA4);
    rd(6'h10, v); chk("R3 ack status", v, 32'h1);
    rd(6'h14, v); chk("R9 active after start", v, cv(4'h8, 1'b1, 16'h0));
    // send
    wr(6'h10, 32'h7FFF); wr(6'h20, 32'h5C); nops = 0; hold = 1'b1;
    wr(6'h14, 32'h2); wait_req();
    rd(6'h14, v); chk("R5 send code", v, cv(4'hC, 1'b1, 16'h2));
    hold = 1'b0; wait_idle();
    chk("R5 op send", 32'(op_log[0]), 1);
    chk("R5 send byte", 32'(dat_log[0]), 32'h5C);
    rd(6'h10, v); chk("R5 ack status", v, 32'h1);
    // repeated start
    wr(6'h10, 32'h7FFF); hold = 1'b1;
    wr(6'h14, 32'h1); wait_req();
    rd(6'h14, v); chk("R3 restart code", v, cv(4'hA, 1'b1, 16'h1));
    hold = 1'b0; wait_idle();
    // receive last
    wr(6'h10, 32'h7FFF); rbyte = 8'h3B; nops = 0; hold = 1'b1;
    wr(6'h14, 32'h18); wait_req();
    rd(6'h14, v); chk("R6 receive code", v, cv(4'hE, 1'b1, 16'h18));
    hold = 1'b0; wait_idle();
    chk("R6 op recv", 32'(op_log[0]), 2);
    chk("R6 nack on last", 32'(nk_log[0]), 1);
    rd(6'h20, v); chk("R6 buffer byte", v, 32'h3B00);
    rd(6'h10, v); chk("R6 rx done", v, 32'h4);
    rd(6'h14, v); chk("R6 bits cleared", v, cv(4'h8, 1'b1, 16'h0));
    // receive deferred while done, resumed by clear
    nops = 0; wr(6'h14, 32'h8); wait_idle();
    chk("R7 skipped", 32'(nops), 0);
    rd(6'h14, v); chk("R7 pending kept", v, cv(4'h8, 1'b1, 16'h8));
    rbyte = 8'h71;
    wr(6'h10, 32'h4); wait_idle();
    chk("R7 resumed op", 32'(nops), 1);
    chk("R7 resumed no nack", 32'(nk_log[0]), 0);
    rd(6'h20, v); chk("R7 resumed byte", v, 32'h7100);
    rd(6'h14, v); chk("R7 pending cleared", v, cv(4'h8, 1'b1, 16'h0));
    // interrupt masking
    repeat (2) @(negedge clk);
    chk("R10 irq masked", 32'(irq), 0);
    wr(6'h0C, 32'h4); repeat (2) @(negedge clk);
    chk("R10 irq enabled", 32'(irq), 1);
    wr(6'h10, 32'h4); repeat (2) @(negedge clk);
    chk("R10 irq cleared", 32'(irq), 0);
    rd(6'h10, v); chk("R10 w1c", v, 0);
    wr(6'h0C, 32'h0);
    // normal stop
    nops = 0; hold = 1'b1;
    wr(6'h14, 32'h20); wait_req();
    rd(6'h14, v); chk("R8 stop code", v, cv(4'hB, 1'b1, 16'h20));
    hold = 1'b0; wait_idle();
    chk("R8 op stop", 32'(op_log[0]), 3);
    rd(6'h10, v); chk("R8 normal stop", v, 32'h10);
    rd(6'h14, v); chk("R8 idle after stop", v, cv(4'h0, 1'b1, 16'h0));
    // abnormal stop
    nops = 0; wr(6'h14, 32'h20); wait_idle();
    chk("R8 abnormal no op", 32'(nops), 0);
    rd(6'h10, v); chk("R8 abnormal flag", v, 32'h30);
    // send NACK
    wr(6'h10, 32'h7FFF);
    wr(6'h14, 32'h1); wait_idle();
    ack_tx = 1'b0; nops = 0;
    wr(6'h14, 32'h2); wait_idle();
    chk("R5 nack ops", 32'(nops), 2);
    chk("R5 nack stop op", 32'(op_log[1]), 3);
    rd(6'h10, v); chk("R5 nack status", v, 32'h3);
    rd(6'h14, v); chk("R5 active after nack", v, cv(4'h8, 1'b1, 16'h0));
    ack_tx = 1'b1;
    // chained start, receive, stop
    wr(6'h10, 32'h7FFF); rbyte = 8'hC6; nops = 0;
    wr(6'h14, 32'h29); wait_idle();
    chk("R9 chain count", 32'(nops), 3);
    chk("R9 chain order", {30'b0, op_log[0]} * 16 + 32'(op_log[1]) * 4 + 32'(op_log[2]), 32'h0B);
    rd(6'h10, v); chk("R9 chain status", v, 32'h15);
    rd(6'h14, v); chk("R9 chain end", v, cv(4'h0, 1'b1, 16'h0));
    // address NACK, bus free: abandon
    wr(6'h10, 32'h7FFF); busy = 1'b0; ack_start = 1'b0; nops = 0;
    wr(6'h14, 32'h21); wait_idle();
    chk("R4 abandon ops", 32'(nops), 1);
    rd(6'h10, v); chk("R4 nak status", v, 32'h2);
    rd(6'h14, v); chk("R4 state kept", v, cv(4'h9, 1'b0, 16'h20));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    total++; bad++;
    $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule